// File: doc/BRIEF.md
# Multicycle Load-Store Processor Core

This block is a small 32-bit integer core that runs one instruction at a time. A five-step controller walks every instruction through fetch, decode with register read, execute or address formation, memory access or branch completion, and register write-back. Each step stores its results in private holding registers: the instruction word, the next sequential address, the two source operands, the extended immediate, the ALU result, the branch condition and the loaded word. Conditional branches end after their fourth step; every other instruction ends after its fifth.

The core has a word-addressed instruction port and a separate data port. Both are meant for simple memory arrays that return read data in the same cycle the address is presented and capture writes on the clock edge. A one-cycle completion pulse and a running cycle count let the surroundings measure how long each instruction took.

The instruction word uses big-endian bit numbering, where field bit 0 is the word's most significant bit. The opcode is in word bits 31..26. The first source register is in 25..21 and the second source register, or the immediate-form destination, is in 20..16. The register-form destination is in 15..11, the 16-bit immediate is in 15..0, and the register-form function code is in 5..0.

Top module: `mcpu_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0, puts the controller at the fetch step and clears the cycle count to 0. While in reset and in the first cycle after it, `imem_addr` is 0 and `retire` is low.
- R2: Fetch latches the word at `imem_addr` and records PC + 4 as the next sequential address. Straight-line code therefore runs from consecutive word addresses.
- R3: Operand fields are taken from fixed positions whatever the opcode: source A from bits 25..21, source B from bits 20..16, and the immediate from bits 15..0, sign-extended from bit 15.
- R4: Opcode 0x00 selects register-register form, with the function in bits 5..0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than, 0x04 shift left, 0x06 logical shift right and 0x07 arithmetic shift right (shift amount = B[4:0]). The result goes to the register in bits 15..11. Any other function code writes no register.
- R5: Immediate forms compute A op sign-extended immediate and write the register in bits 20..16. The opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or and 0x0E xor.
- R6: Opcode 0x23 loads the word at A + immediate into the register in bits 20..16. The offset may be negative.
- R7: Opcode 0x2B writes B to the data word at A + immediate. `dmem_we` is high for exactly one cycle, and no other data word changes.
- R8: Opcode 0x04 branches when A equals zero and opcode 0x05 branches when A is non-zero. The target is the next sequential address plus the immediate. An untaken branch continues at the next sequential address.
- R9: A branch raises `retire` in its fourth cycle; every other instruction raises it in its fifth. The first instruction after reset retires when `cycle_count` is 4.
- R10: Register 0 reads as zero, and any write to it is discarded.
- R11: `imem_addr` holds steady from fetch through the memory step, then changes to the new PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction byte address (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle |
| dmem_re | output | 1 | Load strobe, one cycle |
| dmem_rdata | input | 32 | Data word at dmem_addr, valid in the same cycle |
| retire | output | 1 | Pulse in the last cycle of each instruction |
| cycle_count | output | 32 | Cycles elapsed since reset |

## Verification
The register-register function table is driven with operand pairs chosen to separate near-identical operations. Carry wrap splits add from or. Sign-crossing pairs make signed compare disagree with unsigned compare, and a set top bit makes the arithmetic shift right differ from the logical one. A second program mixes immediate arithmetic with negative and high-bit immediates, a load with a negative offset, writes aimed at register 0 and an undefined function code. This program exposes wrong sign extension, swapped destination fields and writes that should have been suppressed. A branch program runs a taken forward branch over two stores, an untaken branch and a three-pass backward loop. From that run the bench compares every completion time against the four-cycle and five-cycle rule, and the untouched words show whether the skipped stores stayed silent.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned IMM_W  = 16;

    localparam logic [5:0] OPC_RR   = 6'h00;
    localparam logic [5:0] OPC_BEQZ = 6'h04;
    localparam logic [5:0] OPC_BNEZ = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_XORI = 6'h0E;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    localparam logic [5:0] FN_SLL = 6'h04;
    localparam logic [5:0] FN_SRL = 6'h06;
    localparam logic [5:0] FN_SRA = 6'h07;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB
    } step_t;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_t;

    typedef enum logic [2:0] {
        K_NOP, K_RR, K_RI, K_LOAD, K_STORE, K_BRANCH
    } kind_t;

    // Instruction word split at fixed positions (MSB first).
    typedef struct packed {
        logic [5:0]        opc;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        fn;
    } ifmt_t;

    typedef struct packed {
        kind_t   kind;
        alu_op_t op;
        logic    on_zero;
    } dec_t;

    function automatic dec_t decode(input logic [5:0] opc, input logic [5:0] fn);
        dec_t d;
        d.kind    = K_NOP;
        d.op      = ALU_ADD;
        d.on_zero = 1'b0;
        case (opc)
            OPC_RR: begin
                d.kind = K_RR;
                case (fn)
                    FN_ADD:  d.op = ALU_ADD;
                    FN_SUB:  d.op = ALU_SUB;
                    FN_AND:  d.op = ALU_AND;
                    FN_OR:   d.op = ALU_OR;
                    FN_XOR:  d.op = ALU_XOR;
                    FN_SLT:  d.op = ALU_SLT;
                    FN_SLL:  d.op = ALU_SLL;
                    FN_SRL:  d.op = ALU_SRL;
                    FN_SRA:  d.op = ALU_SRA;
                    default: d.kind = K_NOP;
                endcase
            end
            OPC_ADDI: begin d.kind = K_RI; d.op = ALU_ADD; end
            OPC_SLTI: begin d.kind = K_RI; d.op = ALU_SLT; end
            OPC_ANDI: begin d.kind = K_RI; d.op = ALU_AND; end
            OPC_ORI:  begin d.kind = K_RI; d.op = ALU_OR;  end
            OPC_XORI: begin d.kind = K_RI; d.op = ALU_XOR; end
            OPC_LW:   d.kind = K_LOAD;
            OPC_SW:   d.kind = K_STORE;
            OPC_BEQZ: begin d.kind = K_BRANCH; d.on_zero = 1'b1; end
            OPC_BNEZ: d.kind = K_BRANCH;
            default:  d.kind = K_NOP;
        endcase
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic writes_reg(input kind_t k);
        return (k == K_RR) || (k == K_RI) || (k == K_LOAD);
    endfunction

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int unsigned NREG = 32,
    parameter int unsigned DW   = 32,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    localparam int unsigned SH_W = $clog2(DW)
) (
    input  alu_op_t       op,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] z
);
    logic [SH_W-1:0] sh;
    assign sh = y[SH_W-1:0];

    always_comb begin
        case (op)
            ALU_ADD: z = x + y;
            ALU_SUB: z = x - y;
            ALU_AND: z = x & y;
            ALU_OR:  z = x | y;
            ALU_XOR: z = x ^ y;
            ALU_SLT: z = ($signed(x) < $signed(y)) ? DW'(1) : '0;
            ALU_SLL: z = x << sh;
            ALU_SRL: z = x >> sh;
            ALU_SRA: z = DW'($signed(x) >>> sh);
            default: z = x + y;
        endcase
    end

    // R4: a difference added back to the subtrahend restores the minuend
    always_comb begin
        if (op == ALU_SUB) begin
            p_sub_inverse_r4: assert (z + y == x);
        end
    end
endmodule

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
    import mcpu_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  kind_t            kind,
    output step_t            step,
    output logic             retire,
    output logic [CNT_W-1:0] cycles
);
    step_t step_nxt;

    always_comb begin
        case (step)
            ST_FETCH:  step_nxt = ST_DECODE;
            ST_DECODE: step_nxt = ST_EXEC;
            ST_EXEC:   step_nxt = ST_MEM;
            ST_MEM:    step_nxt = (kind == K_BRANCH) ? ST_FETCH : ST_WB;
            default:   step_nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step   <= ST_FETCH;
            cycles <= '0;
        end else begin
            step   <= step_nxt;
            cycles <= cycles + CNT_W'(1);
        end
    end

    assign retire = (step == ST_WB) || ((step == ST_MEM) && (kind == K_BRANCH));

    // R9: execute is always followed by the memory step
    p_exec_then_mem_r9: assert property (@(posedge clk) disable iff (rst)
        (step == ST_EXEC) |=> (step == ST_MEM));

    // R9: every completion is followed by a fresh fetch
    p_retire_restart_r9: assert property (@(posedge clk) disable iff (rst)
        retire |=> (step == ST_FETCH));

    // R9: the cycle count advances by one each clock out of reset
    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cycles == $past(cycles) + CNT_W'(1)));
endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int unsigned NREG  = 32,
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic [WORD_W-1:0] dmem_addr,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic              dmem_we,
    output logic              dmem_re,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic              retire,
    output logic [CNT_W-1:0]  cycle_count
);
    localparam int unsigned AW = $clog2(NREG);
    localparam logic [WORD_W-1:0] STEP_BYTES = WORD_W'(WORD_W / 8);

    // Holding registers between steps
    logic [WORD_W-1:0] pc, ir, npc, opa, opb, imm, alu_q, lmd;
    logic              cond;

    step_t  step;
    ifmt_t  fld;
    dec_t   dec;
    logic [WORD_W-1:0] rf_a, rf_b, alu_x, alu_y, alu_z, wb_data;
    logic [AW-1:0]     wb_addr;
    logic              wb_en, br_take;

    assign fld = ifmt_t'(ir);
    assign dec = decode(fld.opc, fld.fn);

    mcpu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .kind   (dec.kind),
        .step   (step),
        .retire (retire),
        .cycles (cycle_count)
    );

    mcpu_regfile #(.NREG(NREG), .DW(WORD_W)) u_rf (
        .clk  (clk),
        .ra_a (AW'(fld.rs)),
        .ra_b (AW'(fld.rt)),
        .rd_a (rf_a),
        .rd_b (rf_b),
        .we   (wb_en),
        .wa   (wb_addr),
        .wd   (wb_data)
    );

    assign alu_x = (dec.kind == K_BRANCH) ? npc : opa;
    assign alu_y = (dec.kind == K_RR) ? opb : imm;

    mcpu_alu #(.DW(WORD_W)) u_alu (
        .op (dec.op),
        .x  (alu_x),
        .y  (alu_y),
        .z  (alu_z)
    );

    assign br_take = (dec.kind == K_BRANCH) && cond;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            ir    <= '0;
            npc   <= '0;
            opa   <= '0;
            opb   <= '0;
            imm   <= '0;
            alu_q <= '0;
            cond  <= 1'b0;
            lmd   <= '0;
        end else begin
            case (step)
                ST_FETCH: begin
                    ir  <= imem_rdata;
                    npc <= pc + STEP_BYTES;
                end
                ST_DECODE: begin
                    opa <= rf_a;
                    opb <= rf_b;
                    imm <= sext_imm({fld.rd, fld.shamt, fld.fn});
                end
                ST_EXEC: begin
                    alu_q <= alu_z;
                    cond  <= dec.on_zero ? (opa == '0) : (opa != '0);
                end
                ST_MEM: begin
                    if (dec.kind == K_LOAD) begin
                        lmd <= dmem_rdata;
                    end
                    pc <= br_take ? alu_q : npc;
                end
                default: ;
            endcase
        end
    end

    assign wb_en   = (step == ST_WB) && writes_reg(dec.kind);
    assign wb_addr = (dec.kind == K_RR) ? AW'(fld.rd) : AW'(fld.rt);
    assign wb_data = (dec.kind == K_LOAD) ? lmd : alu_q;

    assign imem_addr  = pc;
    assign dmem_addr  = alu_q;
    assign dmem_wdata = opb;
    assign dmem_we    = (step == ST_MEM) && (dec.kind == K_STORE);
    assign dmem_re    = (step == ST_MEM) && (dec.kind == K_LOAD);

    // R1: reset leaves the fetch address at zero and no completion pending
    p_reset_vector_r1: assert property (@(posedge clk)
        rst |=> ((imem_addr == '0) && !retire));

    // R2: the sequential address is the fetched PC plus one word
    p_next_seq_r2: assert property (@(posedge clk) disable iff (rst)
        (step == ST_FETCH) |=> (npc == $past(pc) + STEP_BYTES));

    // R7: a store strobe never lasts two cycles
    p_store_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);

    // R8: a taken branch lands on the address formed in execute
    p_branch_target_r8: assert property (@(posedge clk) disable iff (rst)
        ((step == ST_MEM) && br_take) |=> (pc == $past(alu_q)));

    // R9: a branch goes straight back to fetch after its memory step
    p_branch_short_r9: assert property (@(posedge clk) disable iff (rst)
        ((step == ST_MEM) && (dec.kind == K_BRANCH)) |=> (step == ST_FETCH));

    // R11: the PC moves only at the end of the memory step
    p_pc_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (step != ST_MEM) |=> $stable(pc));
endmodule

// File: tb/tb_mcpu_core.sv
module tb_mcpu_core;

    localparam logic [5:0] O_RR = 6'h00, O_BEQZ = 6'h04, O_BNEZ = 6'h05;
    localparam logic [5:0] O_ADDI = 6'h08, O_SLTI = 6'h0A, O_ANDI = 6'h0C;
    localparam logic [5:0] O_ORI = 6'h0D, O_XORI = 6'h0E, O_LW = 6'h23, O_SW = 6'h2B;
    localparam logic [31:0] MARK = 32'hDEADBEEF;
    localparam int NV = 11;

    // Register-register vectors: operand A, operand B, function, expected
    localparam logic [31:0] VA [NV] = '{32'd5, 32'hFFFFFFFF, 32'd3, 32'hF0F0F0F0,
        32'h0F0F0000, 32'hAAAA5555, 32'hFFFFFFFF, 32'd1, 32'd1, 32'h80000000, 32'h80000000};
    localparam logic [31:0] VB [NV] = '{32'd7, 32'd1, 32'd5, 32'hFF00FF00,
        32'h000000F0, 32'hFFFF0000, 32'd1, 32'hFFFFFFFF, 32'd31, 32'd4, 32'd4};
    localparam logic [5:0] VF [NV] = '{6'h20, 6'h20, 6'h22, 6'h24,
        6'h25, 6'h26, 6'h2A, 6'h2A, 6'h04, 6'h06, 6'h07};
    localparam logic [31:0] VE [NV] = '{32'd12, 32'd0, 32'hFFFFFFFE, 32'hF000F000,
        32'h0F0F00F0, 32'h55555555, 32'd1, 32'd0, 32'h80000000, 32'h08000000, 32'hF8000000};

    // Lengths of the instructions the branch program completes, in order
    localparam int NB = 17;
    localparam int BLEN [NB] = '{5, 4, 5, 4, 5, 5, 5, 5, 5, 4, 5, 5, 4, 5, 5, 4, 5};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re, retire;
    logic [31:0] cycle_count;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic        pre_we = 1'b0;
    logic [5:0]  pre_idx = '0;
    logic [31:0] pre_dat = '0;

    int unsigned rlog [32];
    int          nlog;
    int          nchk = 0;
    int          nfail = 0;
    logic [31:0] trace [6];

    always #10 clk = ~clk;

    mcpu_core dut (
        .clk         (clk),
        .rst         (rst),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .dmem_addr   (dmem_addr),
        .dmem_wdata  (dmem_wdata),
        .dmem_we     (dmem_we),
        .dmem_re     (dmem_re),
        .dmem_rdata  (dmem_rdata),
        .retire      (retire),
        .cycle_count (cycle_count)
    );

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
        else if (pre_we) dmem[pre_idx] <= pre_dat;
    end

    always @(negedge clk) begin
        if (rst) nlog = 0;
        else if (retire && nlog < 32) begin
            rlog[nlog] = cycle_count;
            nlog = nlog + 1;
        end
    end

    function automatic logic [31:0] e_r(logic [5:0] fn, int rd, int rs, int rt);
        return {O_RR, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] e_i(logic [5:0] op, int rt, int rs, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) imem[i] = e_i(O_BEQZ, 0, 0, -4);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_idx = 6'(i); pre_dat = MARK;
        end
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic poke(int idx, logic [31:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_idx = 6'(idx); pre_dat = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic run_prog(int ncyc);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            if (i < 6) trace[i] = imem_addr;
            @(negedge clk);
        end
        rst = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 imem_addr in reset", imem_addr, 32'd0);
        check("R1 retire in reset", {31'd0, retire}, 32'd0);

        // Main loop over register-register vectors
        for (int v = 0; v < NV; v++) begin
            clear_mem();
            poke(0, VA[v]);
            poke(1, VB[v]);
            imem[0] = e_i(O_LW, 1, 0, 0);
            imem[1] = e_i(O_LW, 2, 0, 4);
            imem[2] = e_r(VF[v], 3, 1, 2);
            imem[3] = e_i(O_SW, 3, 0, 8);
            run_prog(26);
            check($sformatf("R4 fn %h vec %0d", VF[v], v), dmem[2], VE[v]);
            check($sformatf("R9 four five-cycle retires vec %0d", v), rlog[3], 32'd19);
            if (v == 0) begin
                // R11/R2: PC steady through the memory step, then next word
                for (int k = 0; k < 5; k++)
                    check($sformatf("R11 imem_addr cycle %0d", k), trace[k], (k == 4) ? 32'd4 : 32'd0);
                check("R1 first retire at count 4", rlog[0], 32'd4);
                check("R6 load to rt field", dmem[3], MARK);
            end
        end

        // Immediate forms, negative load offset, register 0, undefined function
        clear_mem();
        poke(0, 32'd100);
        poke(1, 32'h12345678);
        imem[0]  = e_i(O_LW, 1, 0, 0);
        imem[1]  = e_i(O_ADDI, 4, 1, -3);
        imem[2]  = e_i(O_SW, 4, 0, 12);
        imem[3]  = e_i(O_ANDI, 5, 1, 16'hFFF0);
        imem[4]  = e_i(O_SW, 5, 0, 16);
        imem[5]  = e_i(O_ADDI, 7, 0, 8);
        imem[6]  = e_i(O_LW, 6, 7, -4);
        imem[7]  = e_i(O_SW, 6, 0, 20);
        imem[8]  = e_i(O_ADDI, 0, 0, 5);
        imem[9]  = e_i(O_SW, 0, 0, 24);
        imem[10] = e_i(O_ADDI, 3, 0, 32'h55);
        imem[11] = e_r(6'h3F, 3, 1, 1);
        imem[12] = e_i(O_SW, 3, 0, 28);
        imem[13] = e_i(O_SLTI, 8, 1, 101);
        imem[14] = e_i(O_SW, 8, 0, 32);
        imem[15] = e_i(O_ORI, 9, 0, 16'h8001);
        imem[16] = e_i(O_SW, 9, 0, 36);
        imem[17] = e_i(O_XORI, 10, 9, 16'h7FFF);
        imem[18] = e_i(O_SW, 10, 0, 40);
        run_prog(110);
        check("R5 addi negative imm", dmem[3], 32'd97);
        check("R3 andi sign-extended mask", dmem[4], 32'd96);
        check("R6 load negative offset", dmem[5], 32'h12345678);
        check("R10 r0 write discarded", dmem[6], 32'd0);
        check("R4 undefined function writes nothing", dmem[7], 32'h55);
        check("R5 slti signed", dmem[8], 32'd1);
        check("R3 ori high-bit imm", dmem[9], 32'hFFFF8001);
        check("R5 xori", dmem[10], 32'hFFFFFFFE);
        check("R7 neighbour word untouched", dmem[11], MARK);

        // Branches: taken forward, untaken, backward loop
        clear_mem();
        imem[0]  = e_i(O_ADDI, 1, 0, 0);
        imem[1]  = e_i(O_BEQZ, 0, 1, 8);
        imem[2]  = e_i(O_SW, 1, 0, 8);
        imem[3]  = e_i(O_SW, 1, 0, 12);
        imem[4]  = e_i(O_ADDI, 3, 0, 7);
        imem[5]  = e_i(O_BNEZ, 0, 1, 8);
        imem[6]  = e_i(O_SW, 3, 0, 0);
        imem[7]  = e_i(O_ADDI, 4, 0, 3);
        imem[8]  = e_i(O_ADDI, 5, 0, 0);
        imem[9]  = e_i(O_ADDI, 5, 5, 1);
        imem[10] = e_i(O_ADDI, 4, 4, -1);
        imem[11] = e_i(O_BNEZ, 0, 4, -12);
        imem[12] = e_i(O_SW, 5, 0, 4);
        run_prog(100);
        check("R8 untaken branch falls through", dmem[0], 32'd7);
        check("R8 backward loop count", dmem[1], 32'd3);
        check("R8 taken branch skips first store", dmem[2], MARK);
        check("R8 taken branch skips second store", dmem[3], MARK);
        begin
            int acc = -1;
            for (int k = 0; k < NB; k++) begin
                acc += BLEN[k];
                check($sformatf("R9 retire %0d timing", k), rlog[k], 32'(acc));
            end
        end

        // R1: reset after a run returns the PC and count to zero
        @(negedge clk);
        check("R1 imem_addr after reset", imem_addr, 32'd0);
        rst = 1'b0;
        check("R1 cycle_count after reset", cycle_count, 32'd0);
        check("R1 no retire after reset", {31'd0, retire}, 32'd0);
        @(negedge clk);
        rst = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule